// File: doc/BRIEF.md
# Converter-Clocked Serial Result Receiver

This block sits on the host side of a delta-sigma converter that generates its own serial clock. The converter drives the clock and data-out lines; the host only watches them (chip select is tied low) and drives a single command line back to the converter. Both incoming lines pass through two-flop synchronisers into the system clock domain, where clock edges and the falling data line are detected as single-cycle events.

A frame begins when the data line drops low after a conversion period in which both lines sat high. From then on, every rising converter clock edge captures one bit: 19 bits in all, consisting of a low end-of-conversion marker, a fixed zero, a sign bit and 16 magnitude bits sent MSB first. At the same time the block shifts out an 8-bit channel-select command, one bit per converter clock period, and then holds the command line low. When the frame ends it checks the fixed zero bit and confirms that the data line has gone high again. If both checks pass it presents sign, data and a limit flag along with a one-cycle valid strobe. If either fails it raises an error strobe instead. A watchdog abandons a frame that stalls.

The system clock must run at least eight times faster than the converter clock, so that each command bit is settled before the next rising edge.

Top module: `adcrx_host`

## Requirements
- R1: After reset, adc_sdi is low and neither frame_valid nor frame_err is high.
- R2: While the block waits for a conversion to finish, adc_sdi stays low. Once both lines have been seen high and adc_sdo then falls, the block drives the command MSB (always 1) on adc_sdi before the first rising adc_sck edge.
- R3: The command byte is, MSB first: 1, 0, cmd_enable, cmd_single, cmd_odd, cmd_addr[2], cmd_addr[1], cmd_addr[0]. Bit k (k = 0 is the MSB) is valid at rising edge k+1, and the block advances to the next bit after each falling adc_sck edge.
- R4: From rising edge 9 through rising edge 19, and outside frames, adc_sdi is low.
- R5: adc_sdo is sampled on each of 19 rising adc_sck edges. Bit 1 is the end-of-conversion marker, bit 2 is the fixed zero, bit 3 is the sign, and bits 4 to 19 are res_data[15] down to res_data[0].
- R6: A good frame produces frame_valid for exactly one cycle, together with res_sign and res_data. These outputs hold their values until the next valid strobe.
- R7: res_limit is 1 when the result is sign 1 with data 16'hFFFF, or sign 0 with data 16'h0000. It is 0 otherwise.
- R8: If the fixed zero bit is captured as 1, the frame produces frame_err and no frame_valid, and the result outputs keep their previous values.
- R9: If adc_sdo is not high a few system cycles after the 19th rising edge, the frame produces frame_err and no frame_valid.
- R10: Inside a frame, if no adc_sck edge arrives for more than wd_limit system cycles, the frame is abandoned with no strobe. The next complete frame is then received correctly.
- R11: frame_valid and frame_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sck | input | 1 | Serial clock generated by the converter |
| adc_sdo | input | 1 | Converter data output / end-of-conversion flag |
| adc_sdi | output | 1 | Command bit to the converter |
| cmd_enable | input | 1 | Command field: enable channel update |
| cmd_single | input | 1 | Command field: single-ended selection |
| cmd_odd | input | 1 | Command field: odd channel / polarity |
| cmd_addr | input | 3 | Command field: channel address |
| wd_limit | input | 16 | Stall timeout in system cycles |
| frame_valid | output | 1 | One-cycle strobe for a good frame |
| frame_err | output | 1 | One-cycle strobe for a malformed frame |
| res_sign | output | 1 | Captured sign bit |
| res_data | output | 16 | Captured result, MSB first on the wire |
| res_limit | output | 1 | Result sits at a full-scale limit |

## Verification
A bit counter that is off by one shows up on the next frame as a shifted res_data, or as a spurious frame_err, within one frame time. A command shifter that advances on the wrong edge puts the wrong value on adc_sdi at the very next rising converter edge, and the bench samples adc_sdi at each of those edges. A watchdog that fails to reset the frame state leaves the receiver out of step, so the following frame gives a wrong result or an error.

// File: rtl/adcrx_pkg.sv
package adcrx_pkg;

    localparam int FRAME_BITS = 19;
    localparam int DATA_W     = 16;
    localparam int CMD_BITS   = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int GUARD      = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_SHIFT,
        ST_CHECK
    } rx_state_e;

    typedef struct packed {
        logic              sign;
        logic              limit;
        logic [DATA_W-1:0] data;
    } result_t;

    function automatic logic [CMD_BITS-1:0] build_cmd(
        input logic       en,
        input logic       single,
        input logic       odd,
        input logic [2:0] addr
    );
        return {2'b10, en, single, odd, addr};
    endfunction

    function automatic result_t parse_frame(input logic [FRAME_BITS-1:0] f);
        result_t r;
        r.sign  = f[DATA_W];
        r.data  = f[DATA_W-1:0];
        r.limit = (r.sign && (&r.data)) || (!r.sign && !(|r.data));
        return r;
    endfunction

endpackage

// File: rtl/adcrx_sync.sv
module adcrx_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] chg
);
    logic [N-1:0] stg [0:STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q   = stg[STAGES-1];
    assign chg = stg[STAGES-1] ^ stg[STAGES];
endmodule

// File: rtl/adcrx_cmd.sv
module adcrx_cmd
    import adcrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                advance,
    input  logic                clear,
    input  logic [CMD_BITS-1:0] cmd,
    output logic                sdi
);
    logic [CMD_BITS-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst || clear) sh_q <= '0;
        else if (load)    sh_q <= cmd;
        else if (advance) sh_q <= {sh_q[CMD_BITS-2:0], 1'b0};
    end

    assign sdi = sh_q[CMD_BITS-1];
endmodule

// File: rtl/adcrx_frame.sv
module adcrx_frame
    import adcrx_pkg::*;
#(
    parameter int WD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck,
    input  logic                  sdo,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  sdo_fall,
    input  logic [WD_W-1:0]       wd_limit,
    output logic                  cmd_load,
    output logic                  cmd_adv,
    output logic                  cmd_clr,
    output logic                  done_ok,
    output logic                  done_bad,
    output logic [FRAME_BITS-1:0] frame,
    output rx_state_e             state,
    output logic [CNT_W-1:0]      bit_cnt
);
    rx_state_e             state_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [WD_W-1:0]       wd_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic                  check_now;

    assign cmd_load  = (state_q == ST_CONV) && sdo_fall;
    assign cmd_adv   = (state_q == ST_SHIFT) && sck_fall && (cnt_q != '0);
    assign cmd_clr   = (state_q != ST_SHIFT) && !cmd_load;
    assign check_now = (state_q == ST_CHECK) && (wd_q == WD_W'(GUARD - 1));
    assign done_ok   = check_now && sdo && !sh_q[FRAME_BITS-2];
    assign done_bad  = check_now && !(sdo && !sh_q[FRAME_BITS-2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wd_q    <= '0;
            sh_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sck && sdo) state_q <= ST_CONV;
                end
                ST_CONV: begin
                    if (sdo_fall) begin
                        state_q <= ST_SHIFT;
                        cnt_q   <= '0;
                        wd_q    <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        sh_q <= {sh_q[FRAME_BITS-2:0], sdo};
                        wd_q <= '0;
                        if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                            state_q <= ST_CHECK;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end else if (sck_fall) begin
                        wd_q <= '0;
                    end else if (wd_q >= wd_limit) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        wd_q    <= '0;
                    end else begin
                        wd_q <= wd_q + WD_W'(1);
                    end
                end
                ST_CHECK: begin
                    if (check_now) begin
                        state_q <= ST_IDLE;
                        wd_q    <= '0;
                    end else begin
                        wd_q <= wd_q + WD_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign frame   = sh_q;
    assign state   = state_q;
    assign bit_cnt = cnt_q;
endmodule

// File: rtl/adcrx_host.sv
module adcrx_host
    import adcrx_pkg::*;
#(
    parameter int WD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_sck,
    input  logic              adc_sdo,
    output logic              adc_sdi,
    input  logic              cmd_enable,
    input  logic              cmd_single,
    input  logic              cmd_odd,
    input  logic [2:0]        cmd_addr,
    input  logic [WD_W-1:0]   wd_limit,
    output logic              frame_valid,
    output logic              frame_err,
    output logic              res_sign,
    output logic [DATA_W-1:0] res_data,
    output logic              res_limit
);
    logic [1:0]            line_q;
    logic [1:0]            line_chg;
    logic                  cmd_load, cmd_adv, cmd_clr;
    logic                  done_ok, done_bad;
    logic [FRAME_BITS-1:0] frame;
    rx_state_e             fsm_st;
    logic [CNT_W-1:0]      bit_cnt;
    result_t               res_q;
    logic                  valid_q, err_q;

    adcrx_sync #(.N(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({adc_sdo, adc_sck}),
        .q   (line_q),
        .chg (line_chg)
    );

    adcrx_frame #(.WD_W(WD_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck      (line_q[0]),
        .sdo      (line_q[1]),
        .sck_rise (line_chg[0] && line_q[0]),
        .sck_fall (line_chg[0] && !line_q[0]),
        .sdo_fall (line_chg[1] && !line_q[1]),
        .wd_limit (wd_limit),
        .cmd_load (cmd_load),
        .cmd_adv  (cmd_adv),
        .cmd_clr  (cmd_clr),
        .done_ok  (done_ok),
        .done_bad (done_bad),
        .frame    (frame),
        .state    (fsm_st),
        .bit_cnt  (bit_cnt)
    );

    adcrx_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd_load),
        .advance (cmd_adv),
        .clear   (cmd_clr),
        .cmd     (build_cmd(cmd_enable, cmd_single, cmd_odd, cmd_addr)),
        .sdi     (adc_sdi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= done_ok;
            err_q   <= done_bad;
            if (done_ok) res_q <= parse_frame(frame);
        end
    end

    assign frame_valid = valid_q;
    assign frame_err   = err_q;
    assign res_sign    = res_q.sign;
    assign res_data    = res_q.data;
    assign res_limit   = res_q.limit;
endmodule

// File: rtl/adcrx_host_chk.sv
module adcrx_host_chk
    import adcrx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              adc_sdi,
    input logic              frame_valid,
    input logic              frame_err,
    input logic [DATA_W-1:0] res_data,
    input rx_state_e         fsm_st,
    input logic [CNT_W-1:0]  bit_cnt
);
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && frame_err));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> $stable(res_data));

    p_sdi_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (fsm_st != ST_SHIFT && $past(fsm_st) != ST_SHIFT) |-> !adc_sdi);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS - 1));
endmodule

bind adcrx_host adcrx_host_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_sdi     (adc_sdi),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .res_data    (res_data),
    .fsm_st      (fsm_st),
    .bit_cnt     (bit_cnt)
);

// File: tb/adcrx_host_test.sv
module adcrx_host_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_sck = 1'b1;
    logic        adc_sdo = 1'b1;
    logic        adc_sdi;
    logic        cmd_enable = 1'b0;
    logic        cmd_single = 1'b0;
    logic        cmd_odd = 1'b0;
    logic [2:0]  cmd_addr = 3'd0;
    logic [15:0] wd_limit = 16'd50;
    logic        frame_valid, frame_err, res_sign, res_limit;
    logic [15:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adcrx_host uut (
        .clk(clk), .rst(rst), .adc_sck(adc_sck), .adc_sdo(adc_sdo),
        .adc_sdi(adc_sdi), .cmd_enable(cmd_enable), .cmd_single(cmd_single),
        .cmd_odd(cmd_odd), .cmd_addr(cmd_addr), .wd_limit(wd_limit),
        .frame_valid(frame_valid), .frame_err(frame_err), .res_sign(res_sign),
        .res_data(res_data), .res_limit(res_limit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv_phase();
        adc_sck = 1'b1;
        adc_sdo = 1'b1;
        ticks(8);
        check("R2 sdi low during conversion", 32'(adc_sdi), 32'd0);
        adc_sck = 1'b0;
        adc_sdo = 1'b0;
        ticks(HALF);
    endtask

    // Full converter frame; returns pulses seen afterwards.
    task automatic run_frame(input logic en, input logic sg, input logic od,
                             input logic [2:0] ad, input logic sign,
                             input logic [15:0] data, input logic bad_zero,
                             input logic bad_end, output logic [7:0] cmd_seen,
                             output int nvalid, output int nerr,
                             output logic o_sign, output logic [15:0] o_data,
                             output logic o_limit);
        logic bitv;
        int   late_sdi = 0;
        cmd_enable = en; cmd_single = sg; cmd_odd = od; cmd_addr = ad;
        conv_phase();
        for (int i = 0; i < 19; i++) begin
            if (i == 0)      bitv = 1'b0;
            else if (i == 1) bitv = bad_zero;
            else if (i == 2) bitv = sign;
            else             bitv = data[18-i];
            adc_sdo = bitv;
            if (i != 0) ticks(HALF);
            adc_sck = 1'b1;
            if (i < 8) cmd_seen[7-i] = adc_sdi;
            else if (adc_sdi !== 1'b0) late_sdi++;
            if (i < 18) begin
                ticks(HALF);
                adc_sck = 1'b0;
            end
        end
        check("R4 sdi low after command bits", 32'(late_sdi), 32'd0);
        ticks(1);
        adc_sdo = !bad_end;
        nvalid = 0; nerr = 0;
        o_sign = res_sign; o_data = res_data; o_limit = res_limit;
        for (int k = 0; k < 30; k++) begin
            ticks(1);
            if (frame_valid) begin
                nvalid++;
                o_sign = res_sign; o_data = res_data; o_limit = res_limit;
            end
            if (frame_err) nerr++;
        end
        check("R4 sdi low after frame", 32'(adc_sdi), 32'd0);
    endtask

    task automatic good_frame(input string tag, input logic en, input logic sg,
                              input logic od, input logic [2:0] ad,
                              input logic sign, input logic [15:0] data,
                              input logic exp_limit);
        logic [7:0] cs; int nv, ne; logic s, l; logic [15:0] d;
        run_frame(en, sg, od, ad, sign, data, 1'b0, 1'b0, cs, nv, ne, s, d, l);
        check({tag, " R2 R3 command byte"}, 32'(cs), 32'({2'b10, en, sg, od, ad}));
        check({tag, " R6 one valid strobe"}, 32'(nv), 32'd1);
        check({tag, " R11 no error strobe"}, 32'(ne), 32'd0);
        check({tag, " R5 sign"}, 32'(s), 32'(sign));
        check({tag, " R5 data"}, 32'(d), 32'(data));
        check({tag, " R7 limit flag"}, 32'(l), 32'(exp_limit));
        ticks(50);
        check({tag, " R6 data held"}, 32'(res_data), 32'(data));
    endtask

    task automatic test_reset();
        check("R1 sdi after reset", 32'(adc_sdi), 32'd0);
        check("R1 valid after reset", 32'(frame_valid), 32'd0);
        check("R1 err after reset", 32'(frame_err), 32'd0);
    endtask

    task automatic test_bad_zero();
        logic [7:0] cs; int nv, ne; logic s, l; logic [15:0] d;
        logic [15:0] prev;
        prev = res_data;
        run_frame(1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 16'h5A5A, 1'b1, 1'b0, cs, nv, ne, s, d, l);
        check("R8 error strobe on zero bit", 32'(ne), 32'd1);
        check("R8 no valid on zero bit", 32'(nv), 32'd0);
        check("R8 data unchanged", 32'(res_data), 32'(prev));
    endtask

    task automatic test_bad_end();
        logic [7:0] cs; int nv, ne; logic s, l; logic [15:0] d;
        run_frame(1'b1, 1'b1, 1'b1, 3'd7, 1'b0, 16'h0F0F, 1'b0, 1'b1, cs, nv, ne, s, d, l);
        check("R9 error strobe on missing end", 32'(ne), 32'd1);
        check("R9 no valid on missing end", 32'(nv), 32'd0);
        adc_sdo = 1'b1;
        ticks(10);
    endtask

    task automatic test_timeout();
        int pulses = 0;
        cmd_enable = 1'b1; cmd_single = 1'b0; cmd_odd = 1'b0; cmd_addr = 3'd3;
        conv_phase();
        for (int i = 0; i < 5; i++) begin
            adc_sdo = (i == 2);
            if (i != 0) ticks(HALF);
            adc_sck = 1'b1;
            ticks(HALF);
            if (i < 4) adc_sck = 1'b0;
        end
        adc_sdo = 1'b1;
        for (int k = 0; k < 120; k++) begin
            ticks(1);
            if (frame_valid || frame_err) pulses++;
        end
        check("R10 no strobe on stalled frame", 32'(pulses), 32'd0);
        good_frame("R10 recovery", 1'b1, 1'b1, 1'b0, 3'd6, 1'b1, 16'h8001, 1'b0);
    endtask

    initial begin
        ticks(3);
        rst = 1'b0;
        ticks(2);
        test_reset();
        good_frame("F1", 1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 16'h1234, 1'b0);
        good_frame("F2", 1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 16'hABCD, 1'b0);
        good_frame("F3", 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 16'hFFFF, 1'b1);
        good_frame("F4", 1'b1, 1'b1, 1'b1, 3'd7, 1'b0, 16'h0000, 1'b1);
        good_frame("F5", 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 16'hFFFF, 1'b0);
        test_bad_zero();
        test_bad_end();
        test_timeout();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule